// File: doc/BRIEF.md
# MSI Snoopy Coherence Line Controller

This block keeps the coherence state of a small, direct-mapped set of cache lines for one processor in a shared-bus multiprocessor that uses write-invalidate coherence. Each line stores an address tag and a two-bit state: Invalid, Shared or Modified. The processor side presents one read or write request at a time. Other caches' bus traffic arrives as snoops, each either a read or an intent to write. The block answers with bus requests, write-back requests, a stall for the processor, and the state the addressed line holds once this cycle's snoop is taken into account. Data storage lives elsewhere.

Transitions by state. Invalid goes to Shared on a granted local read miss (bus read) and to Modified on a granted local write miss (bus read-exclusive). Shared stays Shared on local reads and snooped reads. It goes to Modified on a granted local upgrade and to Invalid on a snooped intent-to-write. Modified stays Modified on local reads and writes. A snooped read moves it to Shared and a snooped intent-to-write moves it to Invalid, and both of these raise a write-back. A granted miss that replaces a Modified line of another tag writes that victim back. A snoop and a local request to the same line in the same cycle are resolved snoop first. The local request is then judged against the resulting state.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so `cpu_line_state` reads 00 for any address and a first read requests the bus.
- R2: States are encoded Invalid = 00, Shared = 01, Modified = 10. `cpu_line_state` shows the addressed line's state after this cycle's snoop, and shows 00 when the stored tag differs from the address tag. The line index is the low address bits and the tag is the rest.
- R3: A read to an Invalid or tag-mismatched line raises `bus_req_valid` with command 01 (read). Once granted, the line becomes Shared with the new tag.
- R4: A write to an Invalid or tag-mismatched line requests command 10 (read-exclusive). Once granted, the line becomes Modified.
- R5: A write to a Shared line requests command 11 (upgrade). Once granted, the line becomes Modified. Command 00 means no request.
- R6: Reads of Shared or Modified lines and writes to Modified lines raise no bus request and no stall, and they leave the state unchanged.
- R7: A snooped read that hits a Modified line raises `wb_valid` in the same cycle with `wb_addr` equal to the snooped address, and the line becomes Shared.
- R8: A snooped intent-to-write that hits a line makes it Invalid. `wb_valid` is raised in the same cycle only if the line was Modified.
- R9: A snooped read of a Shared line, or any snoop to an Invalid line or a line with a different tag, changes no state and raises no write-back.
- R10: When a snoop and a local request target the same line in one cycle, the snoop is applied first. The local request's command, stall and hit result follow from the post-snoop state.
- R11: A request that needs the bus keeps `cpu_stall` high and leaves the state unchanged on every cycle without `bus_grant`. The state changes only on the granted cycle.
- R12: A granted miss whose victim line is Modified under another tag raises `wb_valid` with the victim's address (stored tag, index) on the granted cycle. If a snoop write-back occupies that port in the same cycle, the grant is not taken and the stall persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_stall | output | 1 | Processor must hold its request |
| cpu_line_state | output | 2 | Post-snoop state of the addressed line |
| bus_req_valid | output | 1 | Bus transaction wanted |
| bus_req_cmd | output | 2 | 00 none, 01 read, 10 read-exclusive, 11 upgrade |
| bus_req_addr | output | ADDR_W | Address of the bus transaction |
| bus_grant | input | 1 | Bus granted to this cache this cycle |
| snoop_valid | input | 1 | Another cache's transaction observed |
| snoop_write | input | 1 | 1 = intent to write, 0 = read |
| snoop_addr | input | ADDR_W | Snooped line address |
| wb_valid | output | 1 | Write back a dirty line |
| wb_addr | output | ADDR_W | Address of the line to write back |

## Verification
The bench builds the block with 8-bit addresses and 4 lines, which leaves 2 index bits and 6 tag bits. With so few lines, two addresses that differ only above bit 1 fall on the same line. That makes dirty-victim replacement and tag-mismatched snoops easy to produce. Every line can be driven through each state within a few dozen cycles. A snoop and a local request can also be aimed at the same line, or at different lines, in one cycle, so that a snoop write-back and a victim write-back compete for the single port.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_MOD = 2'b10
    } line_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_RDEXC = 2'b10,
        CMD_UPGR  = 2'b11
    } bus_cmd_e;

endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array
    import msi_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 13,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] snp_idx,
    output logic [TAG_W-1:0] snp_tag_rd,
    output line_state_e      snp_state_rd,
    input  logic [IDX_W-1:0] loc_idx,
    output logic [TAG_W-1:0] loc_tag_rd,
    output line_state_e      loc_state_rd,
    input  logic             snp_we,
    input  line_state_e      snp_state_wr,
    input  logic             loc_we,
    input  logic [TAG_W-1:0] loc_tag_wr,
    input  line_state_e      loc_state_wr
);

    line_state_e      state_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[g] <= ST_INV;
                tag_q[g]   <= '0;
            end else if (loc_we && loc_idx == IDX_W'(g)) begin
                state_q[g] <= loc_state_wr;
                tag_q[g]   <= loc_tag_wr;
            end else if (snp_we && snp_idx == IDX_W'(g)) begin
                state_q[g] <= snp_state_wr;
            end
        end
    end

    assign snp_tag_rd   = tag_q[snp_idx];
    assign snp_state_rd = state_q[snp_idx];
    assign loc_tag_rd   = tag_q[loc_idx];
    assign loc_state_rd = state_q[loc_idx];

    // R11: an accepted local update is what the line holds next
    p_local_update_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |=> (state_q[$past(loc_idx)] == $past(loc_state_wr)
                    && tag_q[$past(loc_idx)] == $past(loc_tag_wr)));

    // R8: a snoop update not overridden by a local one lands on its line
    p_snoop_update_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_we && !(loc_we && loc_idx == snp_idx))
            |=> state_q[$past(snp_idx)] == $past(snp_state_wr));

endmodule

// File: rtl/msi_snoop_logic.sv
module msi_snoop_logic
    import msi_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             snoop_valid,
    input  logic             snoop_write,
    input  logic [TAG_W-1:0] snoop_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_state_e      line_state,
    output logic             hit,
    output line_state_e      next_state,
    output logic             need_wb
);

    always_comb begin
        hit        = snoop_valid && (line_state != ST_INV) && (line_tag == snoop_tag);
        next_state = line_state;
        need_wb    = 1'b0;
        if (hit) begin
            unique case (line_state)
                ST_MOD: begin
                    need_wb    = 1'b1;
                    next_state = snoop_write ? ST_INV : ST_SHR;
                end
                ST_SHR: begin
                    next_state = snoop_write ? ST_INV : ST_SHR;
                end
                default: next_state = line_state;
            endcase
        end
    end

endmodule

// File: rtl/msi_local_fsm.sv
module msi_local_fsm
    import msi_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  line_state_e cur_state,
    output logic        need_bus,
    output bus_cmd_e    cmd,
    output line_state_e granted_state
);

    always_comb begin
        need_bus      = 1'b0;
        cmd           = CMD_NONE;
        granted_state = cur_state;
        if (req_valid) begin
            unique case (cur_state)
                ST_INV: begin
                    need_bus      = 1'b1;
                    cmd           = req_write ? CMD_RDEXC : CMD_READ;
                    granted_state = req_write ? ST_MOD : ST_SHR;
                end
                ST_SHR: begin
                    if (req_write) begin
                        need_bus      = 1'b1;
                        cmd           = CMD_UPGR;
                        granted_state = ST_MOD;
                    end
                end
                ST_MOD: begin
                    granted_state = ST_MOD;
                end
                default: granted_state = ST_INV;
            endcase
        end
    end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINES  = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_stall,
    output logic [1:0]        cpu_line_state,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              snoop_valid,
    input  logic              snoop_write,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    logic [TAG_W-1:0] snp_line_tag, cpu_line_tag;
    line_state_e      snp_line_state, cpu_line_stored;
    logic             snp_hit, snp_wb;
    line_state_e      snp_next;
    line_state_e      post_snoop, eff_state, granted_state;
    logic             tag_match, need_bus, victim_dirty, grant_ok, loc_accept;
    bus_cmd_e         cmd;

    assign cpu_idx = cpu_req_addr[IDX_W-1:0];
    assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snoop_addr[IDX_W-1:0];
    assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

    msi_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .snp_idx      (snp_idx),
        .snp_tag_rd   (snp_line_tag),
        .snp_state_rd (snp_line_state),
        .loc_idx      (cpu_idx),
        .loc_tag_rd   (cpu_line_tag),
        .loc_state_rd (cpu_line_stored),
        .snp_we       (snp_hit),
        .snp_state_wr (snp_next),
        .loc_we       (loc_accept),
        .loc_tag_wr   (cpu_tag),
        .loc_state_wr (granted_state)
    );

    msi_snoop_logic #(.TAG_W(TAG_W)) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_write (snoop_write),
        .snoop_tag   (snp_tag),
        .line_tag    (snp_line_tag),
        .line_state  (snp_line_state),
        .hit         (snp_hit),
        .next_state  (snp_next),
        .need_wb     (snp_wb)
    );

    // snoop first: the local side sees the line as the snoop leaves it
    always_comb begin
        post_snoop   = (snp_hit && snp_idx == cpu_idx) ? snp_next : cpu_line_stored;
        tag_match    = (cpu_line_tag == cpu_tag);
        eff_state    = tag_match ? post_snoop : ST_INV;
        victim_dirty = !tag_match && (post_snoop == ST_MOD);
    end

    msi_local_fsm u_local (
        .req_valid     (cpu_req_valid),
        .req_write     (cpu_req_write),
        .cur_state     (eff_state),
        .need_bus      (need_bus),
        .cmd           (cmd),
        .granted_state (granted_state)
    );

    always_comb begin
        grant_ok       = bus_grant && !(victim_dirty && snp_wb);
        loc_accept     = need_bus && grant_ok;
        cpu_stall      = need_bus && !grant_ok;
        bus_req_valid  = need_bus;
        bus_req_cmd    = cmd;
        bus_req_addr   = cpu_req_addr;
        cpu_line_state = eff_state;
        wb_valid       = snp_wb || (victim_dirty && loc_accept);
        wb_addr        = snp_wb ? snoop_addr : {cpu_line_tag, cpu_idx};
    end

    // R11: no grant, no progress
    p_stall_without_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_grant) |-> cpu_stall);

    // R6: requests served without the bus never stall
    p_no_stall_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && !bus_req_valid) |-> !cpu_stall);

    // R5: an upgrade only ever comes from a write
    p_upgrade_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == CMD_UPGR) |-> cpu_req_write);

    // R12: a write-back needs a snoop or an accepted local miss
    p_wb_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (snoop_valid || (bus_req_valid && !cpu_stall)));

    // R3: a granted read leaves the line Shared under the new tag
    p_read_fill_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !cpu_stall && bus_req_cmd == CMD_READ)
            |=> (u_array.state_q[$past(cpu_idx)] == ST_SHR));

endmodule

// File: tb/msi_line_ctrl_test.sv
module msi_line_ctrl_test;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_stall;
    logic [1:0]    cpu_line_state;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic          bus_grant = 1'b0;
    logic          snoop_valid = 1'b0;
    logic          snoop_write = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    msi_line_ctrl #(.ADDR_W(AW), .LINES(4)) uut (
        .clk, .rst_n, .cpu_req_valid, .cpu_req_write, .cpu_req_addr,
        .cpu_stall, .cpu_line_state, .bus_req_valid, .bus_req_cmd,
        .bus_req_addr, .bus_grant, .snoop_valid, .snoop_write, .snoop_addr,
        .wb_valid, .wb_addr
    );

    typedef struct packed {
        logic [3:0] req;
        logic       cv;
        logic       cw;
        logic [7:0] ca;
        logic       sv;
        logic       sw;
        logic [7:0] sa;
        logic       g;
        logic       e_stall;
        logic       e_bv;
        logic [1:0] e_cmd;
        logic       e_wb;
        logic [7:0] e_wa;
        logic [1:0] e_st;
    } vec_t;

    localparam int NV = 29;
    // req, cv,cw,ca, sv,sw,sa, g, stall,bv,cmd, wb,wa, st
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0,1'b0,8'h04, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd0}, // R1 idle after reset
        '{4'd3, 1'b1,1'b0,8'h04, 1'b0,1'b0,8'h00, 1'b0, 1'b1,1'b1,2'd1, 1'b0,8'h00, 2'd0}, // R3 read miss waits
        '{4'd3, 1'b1,1'b0,8'h04, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd1, 1'b0,8'h00, 2'd0}, // R3 granted
        '{4'd6, 1'b1,1'b0,8'h04, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd1}, // R6 read hit Shared
        '{4'd5, 1'b1,1'b1,8'h04, 1'b0,1'b0,8'h00, 1'b0, 1'b1,1'b1,2'd3, 1'b0,8'h00, 2'd1}, // R5 upgrade waits
        '{4'd5, 1'b1,1'b1,8'h04, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd3, 1'b0,8'h00, 2'd1}, // R5 granted
        '{4'd6, 1'b1,1'b1,8'h04, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd2}, // R6 write hit Modified
        '{4'd7, 1'b0,1'b0,8'h04, 1'b1,1'b0,8'h04, 1'b0, 1'b0,1'b0,2'd0, 1'b1,8'h04, 2'd1}, // R7 snoop read on M
        '{4'd8, 1'b0,1'b0,8'h04, 1'b1,1'b1,8'h04, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd0}, // R8 snoop write on S
        '{4'd4, 1'b1,1'b1,8'h05, 1'b0,1'b0,8'h00, 1'b0, 1'b1,1'b1,2'd2, 1'b0,8'h00, 2'd0}, // R4 write miss waits
        '{4'd4, 1'b1,1'b1,8'h05, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd2, 1'b0,8'h00, 2'd0}, // R4 granted
        '{4'd8, 1'b0,1'b0,8'h05, 1'b1,1'b1,8'h05, 1'b0, 1'b0,1'b0,2'd0, 1'b1,8'h05, 2'd0}, // R8 snoop write on M
        '{4'd3, 1'b1,1'b0,8'h06, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd1, 1'b0,8'h00, 2'd0}, // R3 fill line 2
        '{4'd9, 1'b0,1'b0,8'h06, 1'b1,1'b0,8'h06, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd1}, // R9 snoop read on S
        '{4'd9, 1'b0,1'b0,8'h06, 1'b1,1'b1,8'h46, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd1}, // R9 tag mismatch
        '{4'd9, 1'b0,1'b0,8'h06, 1'b1,1'b1,8'h07, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd1}, // R9 invalid line
        '{4'd10,1'b1,1'b1,8'h06, 1'b1,1'b1,8'h06, 1'b1, 1'b0,1'b1,2'd2, 1'b0,8'h00, 2'd0}, // R10 S snooped away
        '{4'd10,1'b1,1'b0,8'h06, 1'b1,1'b0,8'h06, 1'b0, 1'b0,1'b0,2'd0, 1'b1,8'h06, 2'd1}, // R10 read after downgrade
        '{4'd5, 1'b1,1'b1,8'h06, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd3, 1'b0,8'h00, 2'd1}, // R5 upgrade again
        '{4'd10,1'b1,1'b1,8'h06, 1'b1,1'b0,8'h06, 1'b1, 1'b0,1'b1,2'd3, 1'b1,8'h06, 2'd1}, // R10 M to S then upgrade
        '{4'd12,1'b1,1'b0,8'h0A, 1'b0,1'b0,8'h00, 1'b0, 1'b1,1'b1,2'd1, 1'b0,8'h00, 2'd0}, // R12 dirty victim waits
        '{4'd12,1'b1,1'b0,8'h0A, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd1, 1'b1,8'h06, 2'd0}, // R12 victim written back
        '{4'd2, 1'b0,1'b0,8'h06, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd0}, // R2 evicted tag reads 00
        '{4'd4, 1'b1,1'b1,8'h09, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd2, 1'b0,8'h00, 2'd0}, // R4 line 1 to M
        '{4'd4, 1'b1,1'b1,8'h04, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd2, 1'b0,8'h00, 2'd0}, // R4 line 0 to M
        '{4'd12,1'b1,1'b0,8'h0D, 1'b1,1'b0,8'h04, 1'b1, 1'b1,1'b1,2'd1, 1'b1,8'h04, 2'd0}, // R12 port busy, stall
        '{4'd12,1'b1,1'b0,8'h0D, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b1,2'd1, 1'b1,8'h09, 2'd0}, // R12 victim 09
        '{4'd7, 1'b0,1'b0,8'h04, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd1}, // R7 line 0 now S
        '{4'd2, 1'b0,1'b0,8'h0D, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,2'd0, 1'b0,8'h00, 2'd1}  // R2 new tag Shared
    };

    task automatic drive(input logic cv, input logic cw, input logic [7:0] ca,
                         input logic sv, input logic sw, input logic [7:0] sa,
                         input logic g);
        cpu_req_valid = cv;
        cpu_req_write = cw;
        cpu_req_addr  = ca;
        snoop_valid   = sv;
        snoop_write   = sw;
        snoop_addr    = sa;
        bus_grant     = g;
    endtask

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {stall,bv,cmd,wb,wa,st} actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] pack_out(input logic mask_wa);
        return {cpu_stall, bus_req_valid, bus_req_cmd, wb_valid,
                mask_wa ? wb_addr : 8'h00, cpu_line_state};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            drive(v.cv, v.cw, v.ca, v.sv, v.sw, v.sa, v.g);
            #1;
            check($sformatf("R%0d vec %0d", v.req, i),
                  pack_out(v.e_wb),
                  {v.e_stall, v.e_bv, v.e_cmd, v.e_wb, v.e_wa, v.e_st});
            @(negedge clk);
        end

        // R11: miss to line 0 under another tag held without grant
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0);
            #1;
            check("R11 stall held", pack_out(1'b0), {1'b1, 1'b1, 2'd1, 1'b0, 8'h00, 2'd0});
            @(negedge clk);
        end
        drive(1'b0, 1'b0, 8'h04, 1'b0, 1'b0, 8'h00, 1'b0);
        #1;
        check("R11 state untouched by stalled miss", pack_out(1'b0),
              {1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 2'd1});

        // R1: reset mid-run clears every line
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 8'h0D, 1'b0, 1'b0, 8'h00, 1'b0);
        #1;
        check("R1 line 1 Invalid after reset", pack_out(1'b0),
              {1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 2'd0});
        @(negedge clk);
        drive(1'b1, 1'b0, 8'h04, 1'b0, 1'b0, 8'h00, 1'b0);
        #1;
        check("R1 read after reset misses", pack_out(1'b0),
              {1'b1, 1'b1, 2'd1, 1'b0, 8'h00, 2'd0});
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule